// File: doc/BRIEF.md
# Emulation Elapsed Time Counter

This block measures how long emulated code runs. A 32-bit count advances once for every 2 MHz tick enable, which gives a 500 ns resolution. The tick enable is derived from the system clock. After a start, the counter first waits for the first T3 bus state of the first emulated instruction. Only after that T3 state does it count. When emulation halts, counting stops and the count is held.

The host reads the count as two 16-bit halves. Both halves come from one snapshot register that is loaded at the halt, so a low read and a high read always belong to the same instant. The low half wraps modulo 65536 and carries into the high half. When the full count reaches all ones, the count stops there and a sticky saturation flag is raised. At the full rate this takes roughly 36 minutes.

Three emulator events each clear the count, the snapshot and the saturation flag:
- a start from an explicit address,
- a change of the code segment or the instruction pointer,
- a toggle of trace enable.

A start with no clear resumes from the held value. Counting then begins again at the next first T3 state.

Top module: `et_elapsed_timer`

## Requirements
- R1: While counting, the count rises by exactly one in each clock cycle where the tick enable is high. It does not change in cycles where the tick enable is low.
- R2: After the run input rises, nothing is counted until a cycle with the T3 indicator high. Ticks in that T3 cycle and in earlier cycles of the run are not counted.
- R3: When the run input falls, counting stops. The count at that edge is copied into the snapshot register.
- R4: The low read output shows bits [HALF-1:0] of the snapshot and the high read output shows the upper bits. Both stay unchanged during a run unless a clear occurs.
- R5: The low half wraps from all ones to zero and carries one into the high half.
- R6: An increment that makes the count all ones sets the saturation flag. After that, further ticks leave the count at all ones, and the flag stays set until a clear.
- R7: A pulse on any of the three clear inputs sets the count, the snapshot and the saturation flag to zero on the next edge. A clear wins over an increment in the same cycle.
- R8: A run started without a clear continues from the held count.
- R9: After reset, both read outputs and the saturation flag are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | 2 MHz tick enable, one clock wide |
| run_i | input | 1 | High while emulation runs |
| t3_i | input | 1 | High in a T3 bus state |
| clr_start_addr_i | input | 1 | Pulse: start from an explicit address |
| clr_pc_chg_i | input | 1 | Pulse: code segment or instruction pointer changed |
| clr_trace_tgl_i | input | 1 | Pulse: trace enable toggled |
| rd_lo_o | output | CNT_W/2 | Low half of the snapshot |
| rd_hi_o | output | CNT_W/2 | High half of the snapshot |
| sat_o | output | 1 | Sticky saturation flag |

## Verification
The assertions check these behaviours on every cycle:
- the count never moves while halted or while the tick is low;
- the count never decreases except through a clear;
- saturation stays set until a clear;
- a clear leaves zeros one edge later;
- the read outputs stay frozen during a run.

Some behaviours only the bench scenarios can show. These are the gating by the first T3 state, the exact totals across wraps of the low half and across saturation, and resumption from a held value. The bench uses a narrow counter width so that the wrap and saturation corners are reached within a short run.

// File: rtl/et_pkg.sv
package et_pkg;
  typedef enum logic [1:0] {
    ET_IDLE = 2'd0,
    ET_ARM  = 2'd1,
    ET_CNT  = 2'd2
  } et_state_e;
endpackage

// File: rtl/et_run_ctrl.sv
module et_run_ctrl
  import et_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic t3_i,
  output logic cnt_en_o,
  output logic halt_o
);
  et_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ET_IDLE: if (run_i) state_d = ET_ARM;
      ET_ARM: begin
        if (!run_i)    state_d = ET_IDLE;
        else if (t3_i) state_d = ET_CNT;
      end
      ET_CNT:  if (!run_i) state_d = ET_IDLE;
      default: state_d = ET_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ET_IDLE;
    else         state_q <= state_d;
  end

  assign cnt_en_o = (state_q == ET_CNT) && run_i;
  assign halt_o   = (state_q != ET_IDLE) && !run_i;
endmodule

// File: rtl/et_sat_counter.sv
module et_sat_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             sat_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             sat_q, sat_d;
  logic             cnt_we;

  always_comb begin
    cnt_d  = cnt_q;
    sat_d  = sat_q;
    cnt_we = 1'b0;
    if (clr_i) begin
      cnt_d  = '0;
      sat_d  = 1'b0;
      cnt_we = 1'b1;
    end else if (inc_i && (cnt_q != CNT_MAX)) begin
      cnt_d  = cnt_q + 1'b1;
      cnt_we = 1'b1;
      if (cnt_d == CNT_MAX) sat_d = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      sat_q <= 1'b0;
    end else if (cnt_we) begin
      cnt_q <= cnt_d;
      sat_q <= sat_d;
    end
  end

  assign cnt_o = cnt_q;
  assign sat_o = sat_q;
endmodule

// File: rtl/et_snapshot.sv
module et_snapshot #(
  parameter int CNT_W = 32,
  parameter int PARTS = 2
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   clr_i,
  input  logic                   cap_i,
  input  logic [CNT_W-1:0]       cnt_i,
  output logic [CNT_W/PARTS-1:0] part_o [PARTS]
);
  localparam int PART_W = CNT_W / PARTS;

  logic [CNT_W-1:0] snap_q, snap_d;
  logic             snap_we;

  always_comb begin
    snap_we = clr_i || cap_i;
    snap_d  = clr_i ? '0 : cnt_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      snap_q <= '0;
    else if (snap_we) snap_q <= snap_d;
  end

  for (genvar g = 0; g < PARTS; g++) begin : g_part
    assign part_o[g] = snap_q[g*PART_W +: PART_W];
  end
endmodule

// File: rtl/et_elapsed_timer.sv
module et_elapsed_timer #(
  parameter int CNT_W = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_i,
  input  logic               run_i,
  input  logic               t3_i,
  input  logic               clr_start_addr_i,
  input  logic               clr_pc_chg_i,
  input  logic               clr_trace_tgl_i,
  output logic [CNT_W/2-1:0] rd_lo_o,
  output logic [CNT_W/2-1:0] rd_hi_o,
  output logic               sat_o
);
  localparam int HALF_W = CNT_W / 2;

  logic [1:0]        rst_sync_q;
  logic              rst_sync_n;
  logic              clr_any;
  logic              cnt_en;
  logic              halt;
  logic [CNT_W-1:0]  cnt_q;
  logic [HALF_W-1:0] halves [2];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  assign clr_any = clr_start_addr_i | clr_pc_chg_i | clr_trace_tgl_i;

  et_run_ctrl u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_sync_n),
    .run_i    (run_i),
    .t3_i     (t3_i),
    .cnt_en_o (cnt_en),
    .halt_o   (halt)
  );

  et_sat_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_sync_n),
    .clr_i  (clr_any),
    .inc_i  (cnt_en & tick_i),
    .cnt_o  (cnt_q),
    .sat_o  (sat_o)
  );

  et_snapshot #(.CNT_W(CNT_W), .PARTS(2)) u_snap (
    .clk_i  (clk_i),
    .rst_ni (rst_sync_n),
    .clr_i  (clr_any),
    .cap_i  (halt),
    .cnt_i  (cnt_q),
    .part_o (halves)
  );

  assign rd_lo_o = halves[0];
  assign rd_hi_o = halves[1];
endmodule

// File: rtl/et_elapsed_timer_chk.sv
module et_elapsed_timer_chk #(
  parameter int CNT_W = 32
) (
  input logic               clk_i,
  input logic               rst_n,
  input logic               run_i,
  input logic               tick_i,
  input logic               clr_i,
  input logic [CNT_W-1:0]   cnt_i,
  input logic [CNT_W/2-1:0] rd_lo_i,
  input logic [CNT_W/2-1:0] rd_hi_i,
  input logic               sat_i
);
  // R1
  no_tick_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!tick_i && !clr_i) |=> $stable(cnt_i));

  // R3
  halted_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!run_i && !clr_i) |=> $stable(cnt_i));

  // R6
  no_decrease_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    !clr_i |=> (cnt_i >= $past(cnt_i)));

  // R6
  sat_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (sat_i && !clr_i) |=> sat_i);

  // R7
  clear_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    clr_i |=> (rd_lo_i == '0 && rd_hi_i == '0 && !sat_i && cnt_i == '0));

  // R4
  run_read_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (run_i && !clr_i) |=> (run_i ? $stable({rd_hi_i, rd_lo_i}) : 1'b1));
endmodule

bind et_elapsed_timer et_elapsed_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i   (clk_i),
  .rst_n   (rst_sync_n),
  .run_i   (run_i),
  .tick_i  (tick_i),
  .clr_i   (clr_any),
  .cnt_i   (cnt_q),
  .rd_lo_i (rd_lo_o),
  .rd_hi_i (rd_hi_o),
  .sat_i   (sat_o)
);

// File: tb/tb_et_elapsed_timer.sv
module tb_et_elapsed_timer;
  localparam int CW = 8;
  localparam int HW = CW / 2;

  logic clk = 1'b0;
  logic rst_n, tick, run, t3, c_addr, c_pc, c_trc;
  logic [HW-1:0] rd_lo, rd_hi;
  logic sat;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  et_elapsed_timer #(.CNT_W(CW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .run_i(run), .t3_i(t3),
    .clr_start_addr_i(c_addr), .clr_pc_chg_i(c_pc), .clr_trace_tgl_i(c_trc),
    .rd_lo_o(rd_lo), .rd_hi_o(rd_hi), .sat_o(sat)
  );

  // clear kind: 0 none, 1 start address, 2 pc change, 3 trace toggle
  // fields: clear(2) pre_t3_cycles(8) count_cycles(16) expected_count(8) expected_sat(1)
  localparam logic [34:0] VEC [7] = '{
    {2'd1, 8'd3, 16'd5,   8'd5,   1'b0},   // R2 R7
    {2'd0, 8'd2, 16'd20,  8'd25,  1'b0},   // R8 R5
    {2'd2, 8'd0, 16'd16,  8'd16,  1'b0},   // R5 R7
    {2'd3, 8'd1, 16'd3,   8'd3,   1'b0},   // R7
    {2'd0, 8'd0, 16'd252, 8'd255, 1'b1},   // R6
    {2'd0, 8'd4, 16'd10,  8'd255, 1'b1},   // R6
    {2'd1, 8'd0, 16'd7,   8'd7,   1'b0}    // R7
  };

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_clear(input int kind);
    c_addr = (kind == 1);
    c_pc   = (kind == 2);
    c_trc  = (kind == 3);
    cyc(1);
    c_addr = 1'b0; c_pc = 1'b0; c_trc = 1'b0;
  endtask

  // Start a run, wait pre cycles with ticks before T3, then count n ticking cycles and halt.
  task automatic run_seq(input int pre, input int n, input int gap);
    run = 1'b1; tick = 1'b1; t3 = 1'b0;
    cyc(1);
    cyc(pre);
    t3 = 1'b1;
    cyc(1);
    t3 = 1'b0;
    for (int i = 0; i < gap; i++) begin
      tick = 1'b0;
      cyc(1);
    end
    tick = 1'b1;
    cyc(n);
    run = 1'b0;
    cyc(1);
  endtask

  initial begin
    rst_n = 1'b0; tick = 1'b0; run = 1'b0; t3 = 1'b0;
    c_addr = 1'b0; c_pc = 1'b0; c_trc = 1'b0;
    cyc(3);
    rst_n = 1'b1;
    cyc(4);
    // R9 reset values
    check("R9 lo", int'(rd_lo), 0);
    check("R9 hi", int'(rd_hi), 0);
    check("R9 sat", int'(sat), 0);

    for (int v = 0; v < 7; v++) begin
      logic [34:0] e;
      e = VEC[v];
      if (e[34:33] != 2'd0) pulse_clear(int'(e[34:33]));
      run_seq(int'(e[32:25]), int'(e[24:9]), 0);
      check("R3/R4 lo", int'(rd_lo), int'(e[4:1]));
      check("R3/R4 hi", int'(rd_hi), int'(e[8:5]));
      check("R6 sat", int'(sat), int'(e[0]));
    end

    // R1 tick gating: 5 idle-tick cycles after T3, then 2 ticking cycles -> 7 + 2 = 9
    run_seq(1, 2, 5);
    check("R1 gated lo", int'(rd_lo), 9);
    check("R1 gated hi", int'(rd_hi), 0);

    // R4 reads frozen mid-run, then R2 T3 never seen -> no count
    run = 1'b1; tick = 1'b1; t3 = 1'b0;
    cyc(6);
    check("R4 frozen lo", int'(rd_lo), 9);
    run = 1'b0;
    cyc(1);
    check("R2 no T3 lo", int'(rd_lo), 9);

    // R7 clear while halted, and clear beats increment during counting
    pulse_clear(2);
    check("R7 clr lo", int'(rd_lo), 0);
    run = 1'b1; tick = 1'b1; t3 = 1'b1;
    cyc(2);
    t3 = 1'b0;
    cyc(3);
    c_trc = 1'b1;
    cyc(1);
    c_trc = 1'b0;
    cyc(2);
    run = 1'b0;
    cyc(1);
    check("R7 clr priority lo", int'(rd_lo), 2);
    check("R7 clr priority hi", int'(rd_hi), 0);

    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule